// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block decides whether a serial mini-core is running, paused or held in reset. Software uses a small register port to write a 2-bit requested state. The controller accepts the request and applies it after a fixed settling delay. During that delay it shows the request as in progress through a valid flag, which software polls before and after every state change. The block drives two signals to the datapath beside it. The first is a run enable. The second is a one-cycle synchronous clear that flushes FIFOs and zeroes transfer counters.

A separate software-reset register puts the controller back to its power-on condition in one cycle, from any state and even while a transition is still pending. A transfer normally ends by requesting the reset state. That request clears the datapath so the next transfer starts clean. The clear code flushes the datapath the same way and then leaves the core in reset.

Top module: `serial_run_ctl`

## Requirements
- R1: After hardware reset, the applied state is 0 (reset), valid is 1, `run_en` is 0 and `dp_clear` is 0.
- R2: A read of the state address returns the applied state in bits [1:0] and valid in bit 2, with all other bits 0. A read of any other address returns 0.
- R3: A write to the state address while valid is 1 is accepted. Valid reads 0 from the next cycle. The new state and valid = 1 appear together exactly `SETTLE_CYC` (default 2) clock edges after the write edge.
- R4: A write to the state address while valid is 0 is ignored. The pending request and the applied state are unchanged by it.
- R5: Code 1 (run) makes `run_en` 1 from the apply edge. `run_en` is 1 only while the applied state is run.
- R6: Code 3 (pause) applies state 3 with `run_en` 0 and no `dp_clear` pulse, so datapath contents are held.
- R7: Code 0 (reset) applies state 0 and raises `dp_clear` for exactly the one cycle that follows the apply edge.
- R8: Code 2 (clear) raises `dp_clear` for one cycle and settles the applied state to 0 (reset), never reading back as 2.
- R9: A write to the software-reset address with bit 0 = 1 gives state 0, valid 1 and `run_en` 0 on the next cycle, with a one-cycle `dp_clear`. Any pending request is discarded. The same write with bit 0 = 0 has no effect.
- R10: Writes to addresses other than the state and software-reset addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address (combinational read) |
| rd_data | output | DATA_W | Register read data |
| run_en | output | 1 | High while the core is in the run state |
| dp_clear | output | 1 | One-cycle synchronous clear for datapath FIFOs and counters |

## Verification
An accepted state write shows valid low half a cycle after its write edge. The new state, valid = 1 and any `dp_clear` pulse are due after exactly `SETTLE_CYC` further clock edges. `dp_clear` then drops one edge later. A software-reset write takes effect on the very next edge. The bench drives inputs on the falling edge and samples 1 ns after it, once the combinational read data has settled. A cycle-based bench model advances on every rising edge and is compared in every cycle. Directed sequences count the falling edges after each write and check the fixed values due at each one.

// File: rtl/serial_run_ctl_pkg.sv
package serial_run_ctl_pkg;

   typedef enum logic [1:0] {
      CORE_RESET = 2'd0,
      CORE_RUN   = 2'd1,
      CORE_CLEAR = 2'd2,
      CORE_PAUSE = 2'd3
   } core_state_e;

   localparam int STATE_W   = 2;
   localparam int VALID_POS = 2;

endpackage

// File: rtl/rsc_reg_decode.sv
module rsc_reg_decode
   import serial_run_ctl_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter logic [ADDR_W-1:0] STATE_ADDR = '0,
   parameter logic [ADDR_W-1:0] SWRST_ADDR = ADDR_W'(4)
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              state_wr,
   output core_state_e       req_code,
   output logic              soft_rst
);

   if (STATE_ADDR == SWRST_ADDR) begin : g_addr_clash
      $error("rsc_reg_decode: state and software-reset addresses must differ");
   end

   always_comb begin
      state_wr = wr_en && (wr_addr == STATE_ADDR);
      req_code = core_state_e'(wr_data[STATE_W-1:0]);
      soft_rst = wr_en && (wr_addr == SWRST_ADDR) && wr_data[0];
   end

endmodule

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
   parameter int SETTLE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic start,
   output logic busy,
   output logic done
);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("rsc_settle_timer: SETTLE_CYC must be at least 1");
   end

   logic busy_q;

   if (SETTLE_CYC == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          busy_q <= 1'b0;
         else if (soft_rst)   busy_q <= 1'b0;
         else if (busy_q)     busy_q <= 1'b0;
         else if (start)      busy_q <= 1'b1;
      end
      assign done = busy_q;
   end else begin : g_count
      localparam int CNT_W = $clog2(SETTLE_CYC);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (soft_rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
         end
      end
      assign done = busy_q && (cnt_q == '0);

      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CNT_LOAD);
   end

   assign busy = busy_q;

   p_start_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !soft_rst) |=> busy);
   p_idle_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/rsc_state_fsm.sv
module rsc_state_fsm
   import serial_run_ctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        accept,
   input  core_state_e req_code,
   input  logic        apply,
   output core_state_e cur_state,
   output logic        run_en,
   output logic        dp_clear
);

   core_state_e pend_q;
   core_state_e state_q;
   logic        run_q;
   logic        clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q <= CORE_RESET;
      else if (soft_rst)  pend_q <= CORE_RESET;
      else if (accept)    pend_q <= req_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CORE_RESET;
         run_q   <= 1'b0;
         clr_q   <= 1'b0;
      end else if (soft_rst) begin
         state_q <= CORE_RESET;
         run_q   <= 1'b0;
         clr_q   <= 1'b1;
      end else if (apply) begin
         state_q <= (pend_q == CORE_CLEAR) ? CORE_RESET : pend_q;
         run_q   <= (pend_q == CORE_RUN);
         clr_q   <= (pend_q == CORE_RESET) || (pend_q == CORE_CLEAR);
      end else begin
         clr_q   <= 1'b0;
      end
   end

   assign cur_state = state_q;
   assign run_en    = run_q;
   assign dp_clear  = clr_q;

   p_run_only_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run_en == (cur_state == CORE_RUN));
   p_clear_lands_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dp_clear |-> (cur_state == CORE_RESET));
   p_never_shows_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cur_state != CORE_CLEAR);
   p_hold_without_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply && !soft_rst) |=> ($stable(cur_state) && !dp_clear));

endmodule

// File: rtl/rsc_readback.sv
module rsc_readback
   import serial_run_ctl_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter logic [ADDR_W-1:0] STATE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  core_state_e       cur_state,
   input  logic              valid,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W < VALID_POS + 1) begin : g_narrow
      $error("rsc_readback: DATA_W too small for the state register");
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == STATE_ADDR) begin
         rd_data[STATE_W-1:0] = cur_state;
         rd_data[VALID_POS]   = valid;
      end
   end

endmodule

// File: rtl/serial_run_ctl.sv
module serial_run_ctl
   import serial_run_ctl_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter int          SETTLE_CYC = 2,
   parameter logic [ADDR_W-1:0] STATE_ADDR = '0,
   parameter logic [ADDR_W-1:0] SWRST_ADDR = ADDR_W'(4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              run_en,
   output logic              dp_clear
);

   logic        state_wr;
   logic        soft_rst;
   core_state_e req_code;
   logic        busy;
   logic        apply;
   logic        accept;
   logic        valid;
   core_state_e cur_state;

   rsc_reg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STATE_ADDR(STATE_ADDR), .SWRST_ADDR(SWRST_ADDR)
   ) u_decode (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .state_wr(state_wr), .req_code(req_code), .soft_rst(soft_rst)
   );

   assign accept = state_wr && !busy;
   assign valid  = !busy;

   rsc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .start(accept), .busy(busy), .done(apply)
   );

   rsc_state_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .accept(accept), .req_code(req_code), .apply(apply),
      .cur_state(cur_state), .run_en(run_en), .dp_clear(dp_clear)
   );

   rsc_readback #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATE_ADDR(STATE_ADDR)
   ) u_readback (
      .rd_addr(rd_addr), .cur_state(cur_state), .valid(valid),
      .rd_data(rd_data)
   );

   p_valid_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_wr && valid && !soft_rst) |=> !valid);
   p_apply_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> valid);
   p_ignore_busy_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_wr && !valid && !apply) |=> ($stable(cur_state) && !valid));
   p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cur_state == CORE_RESET && valid && !run_en && dp_clear));

endmodule

// File: tb/serial_run_ctl_tb_top.sv
`timescale 1ns/1ps
module serial_run_ctl_tb_top;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int SETTLE = 2;
   localparam logic [ADDR_W-1:0] A_STATE = 8'h00;
   localparam logic [ADDR_W-1:0] A_SWRST = 8'h04;
   localparam logic [ADDR_W-1:0] A_OTHER = 8'h08;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = A_STATE;
   logic [DATA_W-1:0] rd_data;
   logic              run_en;
   logic              dp_clear;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   serial_run_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE),
      .STATE_ADDR(A_STATE), .SWRST_ADDR(A_SWRST)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .run_en(run_en), .dp_clear(dp_clear)
   );

   // cycle model built from the requirements
   logic [1:0] m_state;
   logic       m_busy;
   int         m_cnt;
   logic [1:0] m_pend;
   logic       m_run;
   logic       m_clr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 2'd0; m_busy <= 1'b0; m_cnt <= 0;
         m_pend <= 2'd0; m_run <= 1'b0; m_clr <= 1'b0;
      end else begin
         m_clr <= 1'b0;
         if (wr_en && wr_addr == A_SWRST && wr_data[0]) begin
            m_state <= 2'd0; m_busy <= 1'b0; m_run <= 1'b0; m_clr <= 1'b1;
         end else if (m_busy) begin
            if (m_cnt == 0) begin
               m_busy  <= 1'b0;
               m_state <= (m_pend == 2'd2) ? 2'd0 : m_pend;
               m_run   <= (m_pend == 2'd1);
               m_clr   <= (m_pend == 2'd0) || (m_pend == 2'd2);
            end else begin
               m_cnt <= m_cnt - 1;
            end
         end else if (wr_en && wr_addr == A_STATE) begin
            m_busy <= 1'b1; m_cnt <= SETTLE - 1; m_pend <= wr_data[1:0];
         end
      end
   end

   function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] st,
                                                 input logic vld);
      return (a == A_STATE) ? {29'd0, vld, st} : '0;
   endfunction

   task automatic check(input string req, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle model comparison, 1 ns after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !finished) begin
         check("R2 model rd_data", rd_data, exp_rd(rd_addr, m_state, !m_busy));
         check("R5 model run_en", {31'd0, run_en}, {31'd0, m_run});
         check("R7 model dp_clear", {31'd0, dp_clear}, {31'd0, m_clr});
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic chk_out(input string req, input logic [2:0] rd3,
                          input logic r, input logic c);
      check(req, rd_data, {29'd0, rd3});
      check(req, {31'd0, run_en}, {31'd0, r});
      check(req, {31'd0, dp_clear}, {31'd0, c});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'h5eed_1234);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_out("R1 power-on", 3'b100, 1'b0, 1'b0);

      // R3 and R5: run request
      do_write(A_STATE, 32'd1);
      chk_out("R3 valid low after write", 3'b000, 1'b0, 1'b0);
      step();
      chk_out("R3 still settling", 3'b000, 1'b0, 1'b0);
      step();
      chk_out("R5 run applied", 3'b101, 1'b1, 1'b0);

      // R6 pause, plus R4 ignored write during settling
      do_write(A_STATE, 32'd3);
      do_write(A_STATE, 32'd0);
      step();
      chk_out("R6 pause applied, R4 reset ignored", 3'b111, 1'b0, 1'b0);
      step(); step();
      chk_out("R4 no late apply", 3'b111, 1'b0, 1'b0);

      // R8 clear settles to reset
      do_write(A_STATE, 32'd2);
      step();
      step();
      chk_out("R8 clear pulse, state 0", 3'b100, 1'b0, 1'b1);
      step();
      chk_out("R8 pulse one cycle", 3'b100, 1'b0, 1'b0);

      // R7 reset from run
      do_write(A_STATE, 32'd1);
      step(); step();
      do_write(A_STATE, 32'd0);
      step();
      chk_out("R7 pre-apply keeps run", 3'b001, 1'b1, 1'b0);
      step();
      chk_out("R7 reset clear pulse", 3'b100, 1'b0, 1'b1);
      step();
      chk_out("R7 pulse ends", 3'b100, 1'b0, 1'b0);

      // R9 soft reset mid-transition
      do_write(A_STATE, 32'd1);
      do_write(A_SWRST, 32'd1);
      chk_out("R9 soft reset", 3'b100, 1'b0, 1'b1);
      step(); step();
      chk_out("R9 pending discarded", 3'b100, 1'b0, 1'b0);

      // R9 bit0 = 0 has no effect, R10 unmapped writes
      do_write(A_STATE, 32'd1);
      step(); step();
      do_write(A_SWRST, 32'hFFFF_FFFE);
      chk_out("R9 bit0 zero no effect", 3'b101, 1'b1, 1'b0);
      do_write(A_OTHER, 32'd1);
      step();
      chk_out("R10 unmapped write", 3'b101, 1'b1, 1'b0);
      rd_addr = A_OTHER;
      #1;
      check("R2 other address reads 0", rd_data, 32'd0);
      rd_addr = A_STATE;

      // constrained random phase against the model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         wr_en = ($urandom_range(0, 2) == 0);
         case ($urandom_range(0, 9))
            0:       wr_addr = A_SWRST;
            1:       wr_addr = A_OTHER;
            default: wr_addr = A_STATE;
         endcase
         wr_data = $urandom;
         rd_addr = ($urandom_range(0, 4) == 0) ? A_OTHER : A_STATE;
      end
      @(negedge clk);
      wr_en = 1'b0;
      step(); step(); step();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule